// File: doc/BRIEF.md
# Register File with Deferred Fault Tags

This block is a general-purpose register file for a processor that runs operations ahead of the branch that guards them. Each entry holds a data word and one extra tag bit. The tag marks a value whose computation would have faulted. The fault is not raised when the value is computed. The tag records it, and the register file carries the tag through the dataflow. The fault is raised only if a non-speculative operation consumes the value. If code that never needed the value overwrites it instead, the fault disappears.

Each cycle the datapath presents one operation. The two source register numbers go on the read ports, and an operation kind is given: idle, speculative, non-speculative or check. Two source-use flags, a fault flag and one write request complete it. The register file works out the tag of the result and decides whether the write lands. A trapping non-speculative operation raises an exception request. A check operation on a tagged register raises a redirect request toward recovery code. Register 0 is a constant zero.

Top module: `spec_tag_regfile`

## Requirements
- R1: After reset every register reads data 0 with tag 0, and `exc_req` and `chk_redirect` are low.
- R2: Register 0 always reads data 0 with tag 0, and a write that targets it has no effect.
- R3: A speculative operation (`op_kind` = 1) that has `op_fault` high writes its destination with tag 1 and never causes `exc_req`. This covers a speculative load that would have faulted.
- R4: A speculative operation writes tag 1 when either source that has its use flag high holds tag 1. A tagged source whose use flag is low does not affect the result tag.
- R5: A non-speculative operation (`op_kind` = 2) that uses a tagged source raises `exc_req` in the next cycle, and its write is suppressed.
- R6: A non-speculative operation that has `op_fault` high raises `exc_req` in the next cycle, and its write is suppressed.
- R7: A write from an operation with no fault and no used tagged source stores tag 0. This clears an earlier tag on that register.
- R8: A check operation (`op_kind` = 3) raises `chk_redirect` in the next cycle exactly when the register on read port A holds tag 1. Otherwise `chk_redirect` stays low. A check operation never writes.
- R9: When a write lands on the register that a read port addresses in the same cycle, that port shows the new data and the new tag in that cycle.
- R10: `exc_req` and `chk_redirect` each stay high for one cycle per causing operation. An idle operation (`op_kind` = 0) writes nothing, even with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| rd_a_addr | input | AW (5) | Read port A register number; first source; register tested by a check |
| rd_a_data | output | DW (32) | Read port A data, write-through |
| rd_a_tag | output | 1 | Read port A tag, write-through |
| rd_b_addr | input | AW (5) | Read port B register number; second source |
| rd_b_data | output | DW (32) | Read port B data, write-through |
| rd_b_tag | output | 1 | Read port B tag, write-through |
| op_kind | input | 2 | 0 idle, 1 speculative, 2 non-speculative, 3 check |
| src_a_use | input | 1 | Operation consumes the port A register |
| src_b_use | input | 1 | Operation consumes the port B register |
| op_fault | input | 1 | The operation itself would fault |
| wr_en | input | 1 | Operation writes a result |
| wr_addr | input | AW (5) | Destination register number |
| wr_data | input | DW (32) | Result data |
| exc_req | output | 1 | Exception request, one cycle after the trapping operation |
| chk_redirect | output | 1 | Recovery redirect, one cycle after a check that finds a tag |

## Verification
Both read ports are combinational. Their data and tags, including a value forwarded from a write in the same cycle, are due in the cycle the operation is presented. The write lands at the next rising edge. `exc_req` and `chk_redirect` come from registers, so they are due exactly one cycle after the operation, and the following cycle shows them low again. The driver stamps each expectation with the cycle it is due in: read results with the issue cycle, the two requests with the issue cycle plus one. The monitor samples at the falling edge and compares only the entries due in that cycle. An entry left over from an earlier cycle counts as a failure.

// File: rtl/spec_tag_regfile.sv
`timescale 1ns/1ps
module spec_tag_regfile #(
  parameter int DW = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  output logic          rd_a_tag,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  output logic          rd_b_tag,
  input  logic [1:0]    op_kind,
  input  logic          src_a_use,
  input  logic          src_b_use,
  input  logic          op_fault,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          exc_req,
  output logic          chk_redirect
);

  localparam logic [1:0] K_IDLE  = 2'd0;
  localparam logic [1:0] K_SPEC  = 2'd1;
  localparam logic [1:0] K_SAFE  = 2'd2;
  localparam logic [1:0] K_CHECK = 2'd3;

  logic [DW-1:0] data_q [NREG];
  logic [NREG-1:0] tag_q;

  logic is_spec, is_safe, is_check;
  logic src_tagged, safe_trap, wr_fire, wr_tag, fwd_a, fwd_b;

  assign is_spec  = (op_kind == K_SPEC);
  assign is_safe  = (op_kind == K_SAFE);
  assign is_check = (op_kind == K_CHECK);

  // operation sources see the contents held before this cycle's write
  assign src_tagged = (src_a_use & tag_q[rd_a_addr]) | (src_b_use & tag_q[rd_b_addr]);
  assign safe_trap  = is_safe & (op_fault | src_tagged);
  assign wr_tag     = is_spec & (op_fault | src_tagged);
  assign wr_fire    = wr_en & (wr_addr != '0) & (is_spec | (is_safe & ~safe_trap));

  assign fwd_a = wr_fire & (wr_addr == rd_a_addr);
  assign fwd_b = wr_fire & (wr_addr == rd_b_addr);

  assign rd_a_data = fwd_a ? wr_data : data_q[rd_a_addr];
  assign rd_a_tag  = fwd_a ? wr_tag  : tag_q[rd_a_addr];
  assign rd_b_data = fwd_b ? wr_data : data_q[rd_b_addr];
  assign rd_b_tag  = fwd_b ? wr_tag  : tag_q[rd_b_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) data_q[i] <= '0;
      tag_q        <= '0;
      exc_req      <= 1'b0;
      chk_redirect <= 1'b0;
    end else begin
      if (wr_fire) begin
        data_q[wr_addr] <= wr_data;
        tag_q[wr_addr]  <= wr_tag;
      end
      exc_req      <= safe_trap;
      chk_redirect <= is_check & tag_q[rd_a_addr];
    end
  end

  p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0 && !rd_a_tag));
  p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == '0) |-> (rd_b_data == '0 && !rd_b_tag));
  p_spec_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_SPEC) |=> !exc_req);
  p_fault_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_SPEC && wr_en && op_fault && wr_addr != '0) |=> tag_q[$past(wr_addr)]);
  p_safe_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_SAFE && op_fault) |=> exc_req);
  p_chk_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_CHECK && rd_a_tag) |=> chk_redirect);
  p_chk_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_CHECK && !rd_a_tag) |=> !chk_redirect);
  p_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_SPEC && wr_en && wr_addr == rd_a_addr && wr_addr != '0) |-> (rd_a_data == wr_data));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == K_IDLE) |=> (!exc_req && !chk_redirect));
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req && chk_redirect));

endmodule

// File: tb/sim_spec_tag_regfile.sv
`timescale 1ns/1ps
module sim_spec_tag_regfile;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic rd_a_tag, rd_b_tag, exc_req, chk_redirect;
  logic [1:0] op_kind = 2'd0;
  logic src_a_use = 1'b0, src_b_use = 1'b0, op_fault = 1'b0, wr_en = 1'b0;

  always #10 clk = ~clk;

  spec_tag_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data), .rd_a_tag(rd_a_tag),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .rd_b_tag(rd_b_tag),
    .op_kind(op_kind), .src_a_use(src_a_use), .src_b_use(src_b_use),
    .op_fault(op_fault), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .exc_req(exc_req), .chk_redirect(chk_redirect)
  );

  typedef struct {
    int          cyc;
    int          sig;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdata [32];
  logic [31:0]   mtag;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] actual(int sig);
    case (sig)
      0: return rd_a_data;
      1: return {31'd0, rd_a_tag};
      2: return rd_b_data;
      3: return {31'd0, rd_b_tag};
      4: return {31'd0, exc_req};
      default: return {31'd0, chk_redirect};
    endcase
  endfunction

  function automatic string sig_name(int sig);
    case (sig)
      0: return "rd_a_data";
      1: return "rd_a_tag";
      2: return "rd_b_data";
      3: return "rd_b_tag";
      4: return "exc_req";
      default: return "chk_redirect";
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      logic [31:0] got;
      e = sb.pop_front();
      got = actual(e.sig);
      checks++;
      if (e.cyc != cyc) begin
        errors++;
        $display("FAIL %s %s missed its cycle %0d (now %0d): actual %h expected %h",
                 e.req, sig_name(e.sig), e.cyc, cyc, got, e.val);
      end else if (got !== e.val) begin
        errors++;
        $display("FAIL %s %s cycle %0d: actual %h expected %h",
                 e.req, sig_name(e.sig), cyc, got, e.val);
      end
    end
  end

  task automatic push(int c, int sig, logic [31:0] v, string req);
    exp_t e;
    e.cyc = c; e.sig = sig; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic op(string req, logic [1:0] kind, logic [AW-1:0] a, logic ua,
                    logic [AW-1:0] b, logic ub, logic fault, logic we,
                    logic [AW-1:0] wa, logic [DW-1:0] wd);
    logic src_t, trap, fire, ntag;
    @(posedge clk);
    #1;
    op_kind = kind; rd_a_addr = a; src_a_use = ua; rd_b_addr = b; src_b_use = ub;
    op_fault = fault; wr_en = we; wr_addr = wa; wr_data = wd;
    src_t = (ua & mtag[a]) | (ub & mtag[b]);
    trap  = (kind == 2'd2) & (fault | src_t);
    fire  = we & (wa != 0) & ((kind == 2'd1) | ((kind == 2'd2) & !trap));
    ntag  = (kind == 2'd1) & (fault | src_t);
    push(cyc, 0, (fire && wa == a) ? wd : mdata[a], req);
    push(cyc, 1, {31'd0, (fire && wa == a) ? ntag : mtag[a]}, req);
    push(cyc, 2, (fire && wa == b) ? wd : mdata[b], req);
    push(cyc, 3, {31'd0, (fire && wa == b) ? ntag : mtag[b]}, req);
    push(cyc + 1, 4, {31'd0, trap}, req);
    push(cyc + 1, 5, {31'd0, (kind == 2'd3) & mtag[a]}, req);
    if (fire) begin
      mdata[wa] = wd;
      mtag[wa]  = ntag;
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected finish");
    finish_sim();
  end

  initial begin
    for (int i = 0; i < 32; i++) mdata[i] = '0;
    mtag = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset contents
    op("R1", 2'd0, 5'd5, 0, 5'd31, 0, 0, 0, 5'd0, 32'h0);
    op("R1", 2'd0, 5'd1, 0, 5'd17, 0, 0, 0, 5'd0, 32'h0);
    // R7/R9: clean speculative write, forwarded in the same cycle
    op("R9", 2'd1, 5'd3, 0, 5'd0, 0, 0, 1, 5'd3, 32'h0000_0011);
    op("R7", 2'd2, 5'd0, 0, 5'd8, 0, 0, 1, 5'd8, 32'h0000_0088);
    // R3: faulting speculative load tags its destination, no exception
    op("R3", 2'd1, 5'd3, 1, 5'd4, 0, 1, 1, 5'd4, 32'hDEAD_0004);
    // R4: tag follows a used source
    op("R4", 2'd1, 5'd4, 1, 5'd3, 1, 0, 1, 5'd5, 32'h0000_0055);
    // R4: tagged source with use flag low does not propagate
    op("R4", 2'd1, 5'd4, 0, 5'd3, 1, 0, 1, 5'd6, 32'h0000_0066);
    op("R4", 2'd0, 5'd5, 0, 5'd6, 0, 0, 0, 5'd0, 32'h0);
    // R5: non-speculative use of a tagged source traps, write suppressed
    op("R5", 2'd2, 5'd3, 1, 5'd5, 1, 0, 1, 5'd7, 32'h0000_0077);
    op("R5", 2'd0, 5'd7, 0, 5'd5, 0, 0, 0, 5'd0, 32'h0);
    // R6: non-speculative fault traps, write suppressed
    op("R6", 2'd2, 5'd3, 1, 5'd8, 1, 1, 1, 5'd8, 32'h0000_0999);
    op("R6", 2'd0, 5'd8, 0, 5'd3, 0, 0, 0, 5'd0, 32'h0);
    // R8: checks on untagged, tagged and zero registers
    op("R8", 2'd3, 5'd3, 0, 5'd0, 0, 0, 1, 5'd3, 32'h0000_0BAD);
    op("R8", 2'd3, 5'd5, 0, 5'd4, 0, 0, 0, 5'd0, 32'h0);
    op("R8", 2'd3, 5'd0, 0, 5'd3, 0, 0, 0, 5'd0, 32'h0);
    op("R8", 2'd3, 5'd4, 0, 5'd5, 0, 0, 0, 5'd0, 32'h0);
    // R7: untagged overwrite clears the tag, check now quiet
    op("R7", 2'd2, 5'd3, 1, 5'd6, 1, 0, 1, 5'd5, 32'h0000_5555);
    op("R7", 2'd3, 5'd5, 0, 5'd4, 0, 0, 0, 5'd0, 32'h0);
    op("R7", 2'd1, 5'd4, 0, 5'd0, 0, 0, 1, 5'd4, 32'h0000_4444);
    // R2: writes to register 0 are dropped
    op("R2", 2'd1, 5'd0, 0, 5'd0, 0, 1, 1, 5'd0, 32'hFFFF_FFFF);
    op("R2", 2'd2, 5'd0, 0, 5'd0, 0, 0, 1, 5'd0, 32'h1234_5678);
    op("R2", 2'd0, 5'd0, 0, 5'd0, 0, 0, 0, 5'd0, 32'h0);
    // R10: idle ignores wr_en; requests are single-cycle pulses
    op("R10", 2'd0, 5'd9, 0, 5'd9, 0, 1, 1, 5'd9, 32'h0000_0999);
    op("R10", 2'd0, 5'd9, 0, 5'd3, 0, 0, 0, 5'd0, 32'h0);
    op("R10", 2'd1, 5'd9, 0, 5'd0, 0, 1, 1, 5'd10, 32'h0000_0AAA);
    op("R10", 2'd2, 5'd10, 1, 5'd0, 0, 0, 0, 5'd0, 32'h0);
    op("R10", 2'd3, 5'd10, 0, 5'd0, 0, 0, 0, 5'd0, 32'h0);
    op("R10", 2'd0, 5'd10, 0, 5'd9, 0, 0, 0, 5'd0, 32'h0);
    // R9: port B forwarding of a tagged result
    op("R9", 2'd1, 5'd10, 1, 5'd11, 0, 0, 1, 5'd11, 32'h0000_0BBB);
    op("R9", 2'd0, 5'd11, 0, 5'd10, 0, 0, 0, 5'd0, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 scoreboard drain: actual %0d expected 0", sb.size());
    end
    finish_sim();
  end
endmodule